// File: doc/BRIEF.md
# Programmable 16-bit Event Timer

This block is one programmable up-counter with a matching target register and a mode register. A design places up to three copies, each built with a different `UNIT_IDX`. The index decides which alternative count source the copy may take and how its sync field behaves. Software reaches the three registers through a small word-wide port: a 2-bit address, a write strobe and a read strobe. Read data is combinational.

Each copy counts either every system clock or an alternative tick. Unit 0 may use a dot-clock tick, unit 1 a horizontal-sync tick, and unit 2 the system clock divided by eight. The counter can wrap at the target or run through 0xFFFF. Reaching the target or overflowing records sticky flags and may raise a one-cycle interrupt pulse, either once per mode write or on every event. A blank input lets units 0 and 1 pause during blanking or restart when blanking ends. On unit 2 some sync encodings stop the counter.

Top module: `timer16_unit`

## Requirements
- R1: After reset the count, mode and target registers all read zero and `irq_pulse` is low.
- R2: Register addresses are 0 = count, 1 = mode, 2 = target, and 3 reads zero. Writing address 0 loads the count with `wdata`. Writing address 2 replaces the target at that edge and leaves the count unchanged, apart from its normal step on that edge, which still compares against the old target.
- R3: A mode write stores `wdata[9:0]` and clears mode bits 12:10. It also sets the count to zero, re-arms the one-shot latch and restarts the divide-by-eight prescaler.
- R4: The count rises by one on each enabled tick. With mode bit 8 set, unit 0 counts `dot_tick` and unit 1 counts `hsync_tick`. With mode bit 9 set, unit 2 counts on every eighth clock, the first on the eighth edge after a mode write. Otherwise every clock is a tick.
- R5: A target event occurs on a tick where count+1 equals the target, with the count below 0xFFFF. With mode bit 3 set, the count then becomes zero; otherwise it takes the target value and keeps counting. A target of zero never produces a target event.
- R6: A tick at count 0xFFFF is an overflow event, and the count becomes zero.
- R7: A target event sets mode bits 11 and 10, and an overflow event sets bits 12 and 10. A read strobe on address 1 returns the current mode, then clears bits 12:11 at that edge, unless an event in the same cycle sets them again. Bits 15:13 always read zero.
- R8: With mode bit 4 set, a target event may fire the interrupt; with bit 5 set, an overflow event may. `irq_pulse` goes high for the cycle after the event edge, the same edge at which the count and flags change.
- R9: With mode bit 6 clear, only the first firing event after a mode write produces a pulse. With bit 6 set, every firing event produces a pulse.
- R10: On units 0 and 1 with mode bit 0 set, the field in bits 2:1 sets the sync behaviour. A value of 0 holds the count while `blank` is high. A value of 1 or 2 zeroes the count at an edge where `blank` is low and was high one cycle before. A value of 3 has no effect.
- R11: On unit 2, mode bits 2:0 equal to 001 or 111 halt the count. The values 011 and 101 let it run.
- R12: Priority on one edge, from highest: mode write, then count write, then sync zeroing, then a normal step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dot_tick | input | 1 | Dot-clock tick (unit 0 alternative source) |
| hsync_tick | input | 1 | Horizontal sync tick (unit 1 alternative source) |
| blank | input | 1 | Blanking level used by the sync modes |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on address 1) |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The interesting collision is a read strobe on the mode register in the same cycle as a target or overflow event. The read's clear of bits 12:11 and the event's set of the same flag meet on one edge. The bench sets the count one step short of the target and issues the read exactly on the stepping cycle. It then checks that the read returned the flags as they were before the edge and that the following read still shows the flag set. Random traffic drives mode, count and target writes against ticks and blank edges on all three units. A reference model in the bench predicts every read and every pulse.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

   typedef enum logic [1:0] {
      REG_CNT  = 2'd0,
      REG_MODE = 2'd1,
      REG_TGT  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int MB_SYNC     = 0;
   localparam int MB_SEL_LO   = 1;
   localparam int MB_SEL_HI   = 2;
   localparam int MB_WRAP     = 3;
   localparam int MB_IRQ_TGT  = 4;
   localparam int MB_IRQ_OVF  = 5;
   localparam int MB_REPEAT   = 6;
   localparam int MB_SRC_A    = 8;
   localparam int MB_SRC_B    = 9;
   localparam int MB_EVENT    = 10;
   localparam int MB_HIT_TGT  = 11;
   localparam int MB_HIT_OVF  = 12;
   localparam int MODE_W      = 13;
   localparam int MODE_WR_W   = 10;

endpackage

// File: rtl/timer16_tick_sel.sv
module timer16_tick_sel #(
   parameter int UNIT_IDX = 0,
   parameter int DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_clr,
   input  logic src_a,
   input  logic src_b,
   input  logic dot_tick,
   input  logic hsync_tick,
   output logic tick
);

   generate
      if (UNIT_IDX == 0) begin : g_dot
         logic unused_in;
         assign unused_in = ^{clk, rst_n, pre_clr, src_b, hsync_tick};
         assign tick = src_a ? dot_tick : 1'b1;
      end else if (UNIT_IDX == 1) begin : g_hsync
         logic unused_in;
         assign unused_in = ^{clk, rst_n, pre_clr, src_b, dot_tick};
         assign tick = src_a ? hsync_tick : 1'b1;
      end else begin : g_div
         logic [DIV_LOG2-1:0] pre_q;
         logic                unused_in;
         assign unused_in = ^{src_a, dot_tick, hsync_tick};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (pre_clr) pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
         end
         assign tick = src_b ? (&pre_q) : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/timer16_sync.sv
module timer16_sync #(
   parameter int UNIT_IDX = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       blank,
   input  logic       sync_en,
   input  logic [1:0] sync_sel,
   output logic       hold,
   output logic       clear
);

   generate
      if (UNIT_IDX < 2) begin : g_video
         logic blank_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) blank_q <= 1'b0;
            else        blank_q <= blank;
         end
         assign hold  = sync_en && (sync_sel == 2'd0) && blank;
         assign clear = sync_en && ((sync_sel == 2'd1) || (sync_sel == 2'd2))
                        && blank_q && !blank;
      end else begin : g_stop
         logic unused_in;
         assign unused_in = ^{clk, rst_n, blank};
         assign hold  = sync_en && ((sync_sel == 2'd0) || (sync_sel == 2'd3));
         assign clear = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/timer16_core.sv
module timer16_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_zero,
   input  logic         ld_val,
   input  logic [W-1:0] ld_data,
   input  logic         adv,
   input  logic         wrap_tgt,
   input  logic [W-1:0] target,
   output logic [W-1:0] count,
   output logic         tgt_ev,
   output logic         ovf_ev
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] inc;
   logic         at_top;
   logic         step;

   assign inc    = cnt_q + 1'b1;
   assign at_top = &cnt_q;
   assign step   = adv && !ld_zero && !ld_val;
   assign ovf_ev = step && at_top;
   assign tgt_ev = step && !at_top && (inc == target);
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (ld_zero)           cnt_q <= '0;
      else if (ld_val)            cnt_q <= ld_data;
      else if (tgt_ev && wrap_tgt) cnt_q <= '0;
      else if (step)              cnt_q <= inc;
   end

endmodule

// File: rtl/timer16_unit.sv
module timer16_unit #(
   parameter int UNIT_IDX = 0,
   parameter int DATA_W   = 16,
   parameter int DIV_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_tick,
   input  logic              hsync_tick,
   input  logic              blank,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_pulse
);

   localparam int MW  = timer16_pkg::MODE_W;
   localparam int PAD = DATA_W - MW;

   generate
      if (UNIT_IDX < 0 || UNIT_IDX > 2) begin : g_bad_unit
         $error("timer16_unit: UNIT_IDX must be 0, 1 or 2");
      end
      if (DATA_W < MW) begin : g_bad_width
         $error("timer16_unit: DATA_W too narrow for the mode field");
      end
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("timer16_unit: DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic              wr_mode, wr_cnt, wr_tgt, rd_mode;
   logic [MW-1:0]     mode_q, mode_nx;
   logic [DATA_W-1:0] tgt_q;
   logic [DATA_W-1:0] cnt_w;
   logic              fired_q;
   logic              tick, hold, sync_clr, adv;
   logic              tgt_ev, ovf_ev, fire, allow;

   assign wr_mode = wr_en && (addr == timer16_pkg::REG_MODE);
   assign wr_cnt  = wr_en && (addr == timer16_pkg::REG_CNT);
   assign wr_tgt  = wr_en && (addr == timer16_pkg::REG_TGT);
   assign rd_mode = rd_en && (addr == timer16_pkg::REG_MODE);

   timer16_tick_sel #(.UNIT_IDX(UNIT_IDX), .DIV_LOG2(DIV_LOG2)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .pre_clr    (wr_mode),
      .src_a      (mode_q[timer16_pkg::MB_SRC_A]),
      .src_b      (mode_q[timer16_pkg::MB_SRC_B]),
      .dot_tick   (dot_tick),
      .hsync_tick (hsync_tick),
      .tick       (tick)
   );

   timer16_sync #(.UNIT_IDX(UNIT_IDX)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .blank    (blank),
      .sync_en  (mode_q[timer16_pkg::MB_SYNC]),
      .sync_sel (mode_q[timer16_pkg::MB_SEL_HI:timer16_pkg::MB_SEL_LO]),
      .hold     (hold),
      .clear    (sync_clr)
   );

   assign adv = tick && !hold;

   timer16_core #(.W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_zero  (wr_mode || (sync_clr && !wr_cnt)),
      .ld_val   (wr_cnt),
      .ld_data  (wdata),
      .adv      (adv),
      .wrap_tgt (mode_q[timer16_pkg::MB_WRAP]),
      .target   (tgt_q),
      .count    (cnt_w),
      .tgt_ev   (tgt_ev),
      .ovf_ev   (ovf_ev)
   );

   assign fire  = (tgt_ev && mode_q[timer16_pkg::MB_IRQ_TGT]) ||
                  (ovf_ev && mode_q[timer16_pkg::MB_IRQ_OVF]);
   assign allow = mode_q[timer16_pkg::MB_REPEAT] || !fired_q;

   always_comb begin
      mode_nx = mode_q;
      if (rd_mode) begin
         mode_nx[timer16_pkg::MB_HIT_TGT] = 1'b0;
         mode_nx[timer16_pkg::MB_HIT_OVF] = 1'b0;
      end
      if (tgt_ev) begin
         mode_nx[timer16_pkg::MB_HIT_TGT] = 1'b1;
         mode_nx[timer16_pkg::MB_EVENT]   = 1'b1;
      end
      if (ovf_ev) begin
         mode_nx[timer16_pkg::MB_HIT_OVF] = 1'b1;
         mode_nx[timer16_pkg::MB_EVENT]   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         fired_q   <= 1'b0;
         irq_pulse <= 1'b0;
      end else if (wr_mode) begin
         mode_q    <= {{(MW - timer16_pkg::MODE_WR_W){1'b0}},
                       wdata[timer16_pkg::MODE_WR_W-1:0]};
         fired_q   <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         mode_q    <= mode_nx;
         irq_pulse <= fire && allow;
         if (fire && allow) fired_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_q <= '0;
      else if (wr_tgt) tgt_q <= wdata;
   end

   always_comb begin
      case (addr)
         timer16_pkg::REG_CNT:  rdata = cnt_w;
         timer16_pkg::REG_MODE: rdata = {{PAD{1'b0}}, mode_q};
         timer16_pkg::REG_TGT:  rdata = tgt_q;
         default:               rdata = '0;
      endcase
   end

endmodule

// File: rtl/timer16_chk.sv
module timer16_chk #(
   parameter int DATA_W = 16,
   parameter int MW     = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_mode,
   input logic              wr_cnt,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] count,
   input logic [MW-1:0]     mode,
   input logic              fired,
   input logic              hold,
   input logic              irq_pulse
);

   // R3
   mode_write_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (count == '0) && !fired && (mode[12:10] == 3'b000));

   // R2
   count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (count == $past(wdata)));

   // R9
   oneshot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !mode[6] && !wr_mode) |=> !irq_pulse);

   // R8
   irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (mode[11] || mode[12]));

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !wr_mode && !wr_cnt) |=> $stable(count));

endmodule

bind timer16_unit timer16_chk #(.DATA_W(DATA_W), .MW(timer16_pkg::MODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_mode   (wr_mode),
   .wr_cnt    (wr_cnt),
   .wdata     (wdata),
   .count     (cnt_w),
   .mode      (mode_q),
   .fired     (fired_q),
   .hold      (hold),
   .irq_pulse (irq_pulse)
);

// File: tb/sim_timer16_unit.sv
module sim_timer16_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_dot = 1'b0, b_hs = 1'b0, b_blank = 1'b0;
   logic        b_wr = 1'b0, b_rd = 1'b0;
   logic [1:0]  b_addr = 2'd0;
   logic [15:0] b_wd = 16'h0;
   logic [15:0] rd_w [3];
   logic        irq_w [3];

   int n_chk = 0;
   int n_fail = 0;

   // reference state
   logic [15:0] m_cnt [3];
   logic [15:0] m_tgt [3];
   logic [12:0] m_mode [3];
   logic        m_fired [3];
   logic        m_irq [3];
   logic [2:0]  m_pre;
   logic        m_bq;

   always #5 clk = ~clk;

   timer16_unit #(.UNIT_IDX(0)) u0 (.clk(clk), .rst_n(rst_n), .dot_tick(b_dot),
      .hsync_tick(b_hs), .blank(b_blank), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
      .wdata(b_wd), .rdata(rd_w[0]), .irq_pulse(irq_w[0]));
   timer16_unit #(.UNIT_IDX(1)) u1 (.clk(clk), .rst_n(rst_n), .dot_tick(b_dot),
      .hsync_tick(b_hs), .blank(b_blank), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
      .wdata(b_wd), .rdata(rd_w[1]), .irq_pulse(irq_w[1]));
   timer16_unit #(.UNIT_IDX(2)) u2 (.clk(clk), .rst_n(rst_n), .dot_tick(b_dot),
      .hsync_tick(b_hs), .blank(b_blank), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
      .wdata(b_wd), .rdata(rd_w[2]), .irq_pulse(irq_w[2]));

   task automatic chk(input bit ok, input string tag, input int u,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s unit%0d actual=%h expected=%h", tag, u, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input int u, input logic [1:0] a);
      case (a)
         2'd0:    return m_cnt[u];
         2'd1:    return {3'b000, m_mode[u]};
         2'd2:    return m_tgt[u];
         default: return 16'h0;
      endcase
   endfunction

   task automatic model_step();
      for (int u = 0; u < 3; u++) begin
         logic        tick, hold, clr, adv, tev, oev, fire;
         logic [12:0] md;
         logic [15:0] c;
         md = m_mode[u];
         c  = m_cnt[u];
         tev = 1'b0; oev = 1'b0;
         if (u == 0)      tick = md[8] ? b_dot : 1'b1;
         else if (u == 1) tick = md[8] ? b_hs : 1'b1;
         else             tick = md[9] ? (m_pre == 3'd7) : 1'b1;
         if (u < 2) begin
            hold = md[0] && (md[2:1] == 2'd0) && b_blank;
            clr  = md[0] && (md[2:1] == 2'd1 || md[2:1] == 2'd2) && m_bq && !b_blank;
         end else begin
            hold = md[0] && (md[2:1] == 2'd0 || md[2:1] == 2'd3);
            clr  = 1'b0;
         end
         adv = tick && !hold;
         m_irq[u] = 1'b0;
         if (b_wr && b_addr == 2'd1) begin
            m_cnt[u]   = 16'h0;
            m_mode[u]  = {3'b000, b_wd[9:0]};
            m_fired[u] = 1'b0;
         end else begin
            if (b_wr && b_addr == 2'd0) c = b_wd;
            else if (clr) c = 16'h0;
            else if (adv) begin
               if (c == 16'hFFFF) begin
                  oev = 1'b1; c = 16'h0;
               end else if (16'(c + 16'd1) == m_tgt[u]) begin
                  tev = 1'b1; c = md[3] ? 16'h0 : 16'(c + 16'd1);
               end else c = 16'(c + 16'd1);
            end
            if (b_rd && b_addr == 2'd1) md[12:11] = 2'b00;
            if (tev) begin md[11] = 1'b1; md[10] = 1'b1; end
            if (oev) begin md[12] = 1'b1; md[10] = 1'b1; end
            fire = (tev && md[4]) || (oev && md[5]);
            if (fire && (md[6] || !m_fired[u])) begin
               m_irq[u] = 1'b1; m_fired[u] = 1'b1;
            end
            m_cnt[u]  = c;
            m_mode[u] = md;
         end
         if (b_wr && b_addr == 2'd2) m_tgt[u] = b_wd;
      end
      m_pre = (b_wr && b_addr == 2'd1) ? 3'd0 : 3'(m_pre + 3'd1);
      m_bq  = b_blank;
   endtask

   // one clock: drive at negedge, check read data before the edge, pulse after it
   task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] d, input string tag);
      b_wr = wr; b_rd = rd; b_addr = a; b_wd = d;
      #1;
      for (int u = 0; u < 3; u++)
         chk(rd_w[u] === exp_rd(u, a), tag, u, rd_w[u], exp_rd(u, a));
      model_step();
      @(posedge clk);
      @(negedge clk);
      for (int u = 0; u < 3; u++)
         chk(irq_w[u] === m_irq[u], {tag, " irq R8"}, u, 16'(irq_w[u]), 16'(m_irq[u]));
   endtask

   task automatic idle(input int n, input logic [1:0] a, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, 16'h0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int u = 0; u < 3; u++) begin
         m_cnt[u] = '0; m_tgt[u] = '0; m_mode[u] = '0; m_fired[u] = 1'b0; m_irq[u] = 1'b0;
      end
      m_pre = '0; m_bq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cyc(0, 0, 2'd0, 16'h0, "R1");
      cyc(0, 0, 2'd1, 16'h0, "R1");
      cyc(0, 0, 2'd2, 16'h0, "R1");
      for (int u = 0; u < 3; u++) chk(irq_w[u] === 1'b0, "R1", u, 16'(irq_w[u]), 16'h0);
      cyc(0, 0, 2'd3, 16'h0, "R2");

      // R2 count load and target write
      cyc(1, 0, 2'd0, 16'h1234, "R2");
      idle(2, 2'd0, "R2");
      cyc(1, 0, 2'd2, 16'h1300, "R2");
      idle(2, 2'd0, "R2");
      idle(1, 2'd2, "R2");

      // R3 mode write masks upper bits and re-arms
      cyc(1, 0, 2'd1, 16'hFC18, "R3");
      idle(2, 2'd1, "R3");
      idle(1, 2'd0, "R3");

      // R5 wrap at target with target interrupt
      cyc(1, 0, 2'd2, 16'h0010, "R5");
      cyc(1, 0, 2'd0, 16'h000C, "R5");
      idle(6, 2'd0, "R5");
      cyc(0, 1, 2'd1, 16'h0, "R7");
      idle(2, 2'd1, "R7");

      // R6 and R9 overflow one-shot, then repeat
      cyc(1, 0, 2'd1, 16'h0020, "R9");
      cyc(1, 0, 2'd0, 16'hFFFD, "R6");
      idle(4, 2'd0, "R6 R8");
      cyc(1, 0, 2'd0, 16'hFFFE, "R9");
      idle(4, 2'd1, "R9");
      cyc(1, 0, 2'd1, 16'h0060, "R9");
      cyc(1, 0, 2'd0, 16'hFFFE, "R9");
      idle(3, 2'd1, "R9");
      cyc(1, 0, 2'd0, 16'hFFFF, "R9");
      idle(2, 2'd1, "R9");

      // R7 read-clear in the same cycle as a target event
      cyc(1, 0, 2'd1, 16'h0018, "R7");
      cyc(1, 0, 2'd2, 16'h0005, "R7");
      cyc(1, 0, 2'd0, 16'h0003, "R7");
      cyc(0, 0, 2'd1, 16'h0, "R7");
      cyc(0, 1, 2'd1, 16'h0, "R7");
      idle(2, 2'd1, "R7");

      // R10 pause during blank (units 0,1); R11 halt on unit 2
      cyc(1, 0, 2'd1, 16'h0001, "R10 R11");
      b_blank = 1'b1; idle(4, 2'd0, "R10 R11");
      b_blank = 1'b0; idle(3, 2'd0, "R10 R11");
      // R10 zero when blanking ends, selectors 1 and 2
      cyc(1, 0, 2'd1, 16'h0003, "R10");
      idle(3, 2'd0, "R10");
      b_blank = 1'b1; idle(3, 2'd0, "R10");
      b_blank = 1'b0; idle(3, 2'd0, "R10");
      cyc(1, 0, 2'd1, 16'h0005, "R10");
      b_blank = 1'b1; idle(2, 2'd0, "R10");
      b_blank = 1'b0; idle(2, 2'd0, "R10");
      // R11 encoding 111 halts unit 2, selector 3 is neutral on units 0,1
      cyc(1, 0, 2'd1, 16'h0007, "R11");
      b_blank = 1'b1; idle(2, 2'd0, "R11");
      b_blank = 1'b0; idle(3, 2'd0, "R11");

      // R4 alternative sources
      cyc(1, 0, 2'd1, 16'h0100, "R4");
      for (int i = 0; i < 12; i++) begin
         b_dot = (i % 2) == 0;
         b_hs  = (i % 3) == 0;
         cyc(0, 0, 2'd0, 16'h0, "R4");
      end
      b_dot = 1'b0; b_hs = 1'b0;
      cyc(1, 0, 2'd1, 16'h0200, "R4");
      idle(20, 2'd0, "R4");

      // R12 count write against blank-end zeroing, mode write against both
      cyc(1, 0, 2'd1, 16'h0003, "R12");
      b_blank = 1'b1; idle(2, 2'd0, "R12");
      b_blank = 1'b0; cyc(1, 0, 2'd0, 16'h0ABC, "R12");
      idle(2, 2'd0, "R12");
      b_blank = 1'b1; idle(1, 2'd0, "R12");
      b_blank = 1'b0; cyc(1, 0, 2'd1, 16'h0005, "R12");
      idle(2, 2'd0, "R12");

      // random mixture
      for (int i = 0; i < 5000; i++) begin
         int          r;
         logic        wr, rd;
         logic [1:0]  a;
         logic [15:0] d;
         r  = int'($urandom_range(0, 15));
         wr = 1'b0; rd = ($urandom_range(0, 3) == 0);
         a  = 2'($urandom_range(0, 3));
         d  = 16'($urandom);
         if (r == 0) begin
            wr = 1'b1; a = 2'd1;
         end else if (r == 1 || r == 2) begin
            wr = 1'b1; a = 2'd0;
            case ($urandom_range(0, 2))
               0:       d = 16'hFFF8 | 16'($urandom_range(0, 7));
               1:       d = 16'(m_tgt[0] - 16'($urandom_range(0, 4)));
               default: d = 16'($urandom);
            endcase
         end else if (r == 3) begin
            wr = 1'b1; a = 2'd2; d = 16'($urandom_range(0, 63));
         end
         b_dot = ($urandom_range(0, 2) == 0);
         b_hs  = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 23) == 0) b_blank = ~b_blank;
         cyc(wr, rd, a, d, "R4/R7/R12 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule